// File: doc/BRIEF.md
# A/D Converter Stop and Freeze Mode Gate

This block decides how a queued A/D converter peripheral behaves when software puts it into low-power stop or when a debugger freezes the system. It takes three bits from the module configuration register: stop, freeze-enable and supervisor-space. It also takes an external debug freeze line. From these it drives the converter clock enable, aborts or pauses the conversion sequencer, and holds the periodic timer in reset. After stop is released it times a recovery interval, and no new conversion may start until that interval has run out.

The bus-side register decoder presents each access to this block. An access consists of a register group code, a direction and a privilege level. The block returns a write strobe, a read strobe and gated read data, or it refuses the access. A refused access reads as zero, drops the write and raises an access-error output while the access is presented. On entry to stop, the block also pulses one clear line for each register group that must return to its reset value.

Out of scope and only modelled by strobes are the converter itself, the sequencer, and the command and result RAM contents.

Top module: `adc_mode_gate`

## Requirements
- R1: While `stop_i` is 1, `qclk_en_o` is 0, `timer_rst_o` is 1 and `start_ok_o` is 0.
- R2: If a conversion is busy (`seq_busy_o`=1) in the first cycle `stop_i` is 1, `seq_abort_o` is 1 in that cycle only, and `seq_busy_o` is 0 from the next cycle.
- R3: During stop, the configuration (code 0), interrupt (code 1) and test (code 2) groups accept both reads and writes.
- R4: During stop, the port (code 3), control-0 (code 4), control-1/2 (code 5) and status (code 6) groups accept reads and refuse writes.
- R5: During stop, every access to the RAM group (code 7) is refused.
- R6: In the first cycle `stop_i` is 1, `clr_vec_o` equals 8'h60 (bit 5 for control-1/2 and bit 6 for status). In all other cycles it is 0.
- R7: After `stop_i` falls, `conv_ready_o` stays 0 for REC_CYCLES-1 rising edges and is 1 after the REC_CYCLES-th edge.
- R8: With `frz_en_i`=1 and `freeze_i`=1, a busy conversion stays busy, without abort, until `conv_done_i`. After that, `seq_halt_o` is 1, `start_ok_o` is 0, and `conv_start_i` does not set busy.
- R9: With `frz_en_i`=0, `freeze_i` has no effect: `seq_halt_o` stays 0 and `start_ok_o` stays 1 while idle and ready.
- R10: With `supv_i`=0, a user access (`acc_priv_i`=0) to groups 0, 1 or 2 is refused, and a user access to groups 3 through 7 is accepted outside stop.
- R11: With `supv_i`=1, every user access to any group is refused, and supervisor accesses are accepted outside stop.
- R12: A refused access gives `rdata_o`=0, `acc_wr_o`=0, `acc_rd_o`=0 and `acc_err_o`=1. An accepted read gives `acc_rd_o`=1, `rdata_o`=`rdata_i` and `acc_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop bit from configuration register |
| frz_en_i | input | 1 | Freeze-enable bit |
| supv_i | input | 1 | Supervisor-space bit |
| freeze_i | input | 1 | External debug freeze line |
| conv_start_i | input | 1 | Sequencer requests a conversion start |
| conv_done_i | input | 1 | Current conversion finished |
| acc_valid_i | input | 1 | Register access presented |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_priv_i | input | 1 | 1 = supervisor access |
| acc_grp_i | input | 3 | Register group code (0..7) |
| rdata_i | input | DW | Read data from register file |
| qclk_en_o | output | 1 | Converter clock enable |
| timer_rst_o | output | 1 | Periodic timer held in reset |
| conv_ready_o | output | 1 | Recovery interval complete |
| start_ok_o | output | 1 | A conversion start is accepted |
| seq_busy_o | output | 1 | Conversion in progress |
| seq_abort_o | output | 1 | Sequence aborted by stop |
| seq_halt_o | output | 1 | Sequencer halted by freeze |
| clr_vec_o | output | 8 | Per-group reset pulse on stop entry |
| acc_wr_o | output | 1 | Write accepted |
| acc_rd_o | output | 1 | Read accepted |
| acc_err_o | output | 1 | Access refused |
| rdata_o | output | DW | Gated read data |

## Verification
The bench enters stop in the middle of a conversion. A design that fails to abort would leave busy set. A design that clears the wrong groups, or clears them for more than one cycle, would show the wrong `clr_vec_o` value. Every group is probed in both directions during stop to catch a mixed-up read-only mask, and the RAM group is probed to catch a missing refusal. The recovery count is sampled at the edge before expiry and at the expiry edge, which exposes off-by-one counters. Freeze is raised while a conversion is busy, which catches a design that halts at once instead of waiting for completion. Both supervisor levels are exercised with user accesses to every group.

// File: rtl/adc_mode_pkg.sv
package adc_mode_pkg;
  localparam int unsigned NGRP = 8;

  typedef enum logic [2:0] {
    GRP_CFG   = 3'd0,
    GRP_INT   = 3'd1,
    GRP_TEST  = 3'd2,
    GRP_PORT  = 3'd3,
    GRP_CTL0  = 3'd4,
    GRP_CTL12 = 3'd5,
    GRP_STAT  = 3'd6,
    GRP_RAM   = 3'd7
  } grp_e;

  // groups fully accessible in stop
  localparam logic [NGRP-1:0] STOP_RW_MASK  = 8'b0000_0111;
  // groups read-only in stop
  localparam logic [NGRP-1:0] STOP_RO_MASK  = 8'b0111_1000;
  // groups cleared on stop entry
  localparam logic [NGRP-1:0] STOP_CLR_MASK = 8'b0110_0000;
  // groups that always need supervisor privilege
  localparam logic [NGRP-1:0] PRIV_BASE_MASK = 8'b0000_0111;
endpackage

// File: rtl/adc_mode_access.sv
module adc_mode_access
  import adc_mode_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          stop_i,
  input  logic          supv_i,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic          priv_i,
  input  logic [2:0]    grp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          wr_o,
  output logic          rd_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o
);
  logic [NGRP-1:0] rd_ok, wr_ok, priv_ok;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign rd_ok[g]   = ~stop_i | STOP_RW_MASK[g] | STOP_RO_MASK[g];
    assign wr_ok[g]   = ~stop_i | STOP_RW_MASK[g];
    assign priv_ok[g] = priv_i | ~(supv_i | PRIV_BASE_MASK[g]);
  end

  logic dir_ok, ok;
  always_comb begin
    dir_ok  = write_i ? wr_ok[grp_i] : rd_ok[grp_i];
    ok      = valid_i & priv_ok[grp_i] & dir_ok;
    wr_o    = ok & write_i;
    rd_o    = ok & ~write_i;
    err_o   = valid_i & ~ok;
    rdata_o = rd_o ? rdata_i : '0;
  end
endmodule

// File: rtl/adc_mode_recov.sv
module adc_mode_recov #(
  parameter int unsigned REC_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(REC_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (stop_i)          cnt_q <= CW'(REC_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0) & ~stop_i;
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic stop_entry_i,
  input  logic frz_req_i,
  input  logic ready_i,
  input  logic start_i,
  input  logic done_i,
  output logic start_ok_o,
  output logic busy_o,
  output logic abort_o,
  output logic halt_o
);
  logic busy_q;

  assign start_ok_o = ready_i & ~stop_i & ~frz_req_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      busy_q <= 1'b0;
    else if (stop_i || done_i)        busy_q <= 1'b0;
    else if (start_i && start_ok_o)   busy_q <= 1'b1;
  end

  assign busy_o  = busy_q;
  assign abort_o = stop_entry_i & busy_q;
  // freeze waits for the running conversion to finish
  assign halt_o  = frz_req_i & ~busy_q;
endmodule

// File: rtl/adc_mode_gate.sv
module adc_mode_gate
  import adc_mode_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 16,
  parameter int unsigned DW         = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_i,
  input  logic          frz_en_i,
  input  logic          supv_i,
  input  logic          freeze_i,
  input  logic          conv_start_i,
  input  logic          conv_done_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic          acc_priv_i,
  input  logic [2:0]    acc_grp_i,
  input  logic [DW-1:0] rdata_i,
  output logic          qclk_en_o,
  output logic          timer_rst_o,
  output logic          conv_ready_o,
  output logic          start_ok_o,
  output logic          seq_busy_o,
  output logic          seq_abort_o,
  output logic          seq_halt_o,
  output logic [7:0]    clr_vec_o,
  output logic          acc_wr_o,
  output logic          acc_rd_o,
  output logic          acc_err_o,
  output logic [DW-1:0] rdata_o
);
  logic stop_q, stop_entry, frz_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= 1'b0;
    else         stop_q <= stop_i;
  end

  assign stop_entry  = stop_i & ~stop_q;
  assign frz_req     = freeze_i & frz_en_i;
  assign qclk_en_o   = ~stop_i;
  assign timer_rst_o = stop_i;
  assign clr_vec_o   = {NGRP{stop_entry}} & STOP_CLR_MASK;

  adc_mode_recov #(.REC_CYCLES(REC_CYCLES)) u_recov (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (stop_i),
    .ready_o (conv_ready_o)
  );

  adc_mode_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_i       (stop_i),
    .stop_entry_i (stop_entry),
    .frz_req_i    (frz_req),
    .ready_i      (conv_ready_o),
    .start_i      (conv_start_i),
    .done_i       (conv_done_i),
    .start_ok_o   (start_ok_o),
    .busy_o       (seq_busy_o),
    .abort_o      (seq_abort_o),
    .halt_o       (seq_halt_o)
  );

  adc_mode_access #(.DW(DW)) u_acc (
    .stop_i  (stop_i),
    .supv_i  (supv_i),
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .priv_i  (acc_priv_i),
    .grp_i   (acc_grp_i),
    .rdata_i (rdata_i),
    .wr_o    (acc_wr_o),
    .rd_o    (acc_rd_o),
    .err_o   (acc_err_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/adc_mode_gate_chk.sv
module adc_mode_gate_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_i,
  input logic          frz_en_i,
  input logic          freeze_i,
  input logic          conv_done_i,
  input logic          acc_valid_i,
  input logic [2:0]    acc_grp_i,
  input logic          qclk_en_o,
  input logic          timer_rst_o,
  input logic          conv_ready_o,
  input logic          start_ok_o,
  input logic          seq_busy_o,
  input logic          seq_abort_o,
  input logic          seq_halt_o,
  input logic          acc_wr_o,
  input logic          acc_rd_o,
  input logic          acc_err_o,
  input logic [DW-1:0] rdata_o
);
  assert_stop_gates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> (!qclk_en_o && timer_rst_o && !start_ok_o));

  assert_abort_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_abort_o |=> !seq_busy_o);

  assert_ram_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && acc_valid_i && acc_grp_i == 3'd7) |-> (acc_err_o && !acc_wr_o && !acc_rd_o));

  assert_recovery_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_i) |-> !conv_ready_o);

  assert_freeze_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en_i && freeze_i && seq_busy_o && !stop_i && !conv_done_i) |=> seq_busy_o);

  assert_halt_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_halt_o |-> !start_ok_o);

  assert_no_frz_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frz_en_i |-> !seq_halt_o);

  assert_refused_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> (rdata_o == '0 && !acc_wr_o && !acc_rd_o));
endmodule

bind adc_mode_gate adc_mode_gate_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .frz_en_i     (frz_en_i),
  .freeze_i     (freeze_i),
  .conv_done_i  (conv_done_i),
  .acc_valid_i  (acc_valid_i),
  .acc_grp_i    (acc_grp_i),
  .qclk_en_o    (qclk_en_o),
  .timer_rst_o  (timer_rst_o),
  .conv_ready_o (conv_ready_o),
  .start_ok_o   (start_ok_o),
  .seq_busy_o   (seq_busy_o),
  .seq_abort_o  (seq_abort_o),
  .seq_halt_o   (seq_halt_o),
  .acc_wr_o     (acc_wr_o),
  .acc_rd_o     (acc_rd_o),
  .acc_err_o    (acc_err_o),
  .rdata_o      (rdata_o)
);

// File: tb/adc_mode_gate_tb.sv
module adc_mode_gate_tb;
  localparam int unsigned REC = 16;
  localparam int unsigned DW  = 16;
  localparam logic [DW-1:0] RD_PAT = 16'hA5C3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stop_i = 0, frz_en_i = 0, supv_i = 0, freeze_i = 0;
  logic conv_start_i = 0, conv_done_i = 0;
  logic acc_valid_i = 0, acc_write_i = 0, acc_priv_i = 0;
  logic [2:0] acc_grp_i = '0;
  logic [DW-1:0] rdata_i = RD_PAT;
  logic qclk_en_o, timer_rst_o, conv_ready_o, start_ok_o, seq_busy_o;
  logic seq_abort_o, seq_halt_o, acc_wr_o, acc_rd_o, acc_err_o;
  logic [7:0] clr_vec_o;
  logic [DW-1:0] rdata_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  adc_mode_gate #(.REC_CYCLES(REC), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i), .frz_en_i(frz_en_i),
    .supv_i(supv_i), .freeze_i(freeze_i), .conv_start_i(conv_start_i),
    .conv_done_i(conv_done_i), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_priv_i(acc_priv_i), .acc_grp_i(acc_grp_i), .rdata_i(rdata_i),
    .qclk_en_o(qclk_en_o), .timer_rst_o(timer_rst_o), .conv_ready_o(conv_ready_o),
    .start_ok_o(start_ok_o), .seq_busy_o(seq_busy_o), .seq_abort_o(seq_abort_o),
    .seq_halt_o(seq_halt_o), .clr_vec_o(clr_vec_o), .acc_wr_o(acc_wr_o),
    .acc_rd_o(acc_rd_o), .acc_err_o(acc_err_o), .rdata_o(rdata_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access cycle; returns {err,wr,rd} and checks rdata
  task automatic access(input string req, input int grp, input bit wr, input bit priv,
                        input bit exp_ok);
    @(negedge clk);
    acc_valid_i = 1; acc_write_i = wr; acc_priv_i = priv; acc_grp_i = 3'(grp);
    #2;
    chk(req, {acc_err_o, acc_wr_o, acc_rd_o},
        exp_ok ? (wr ? 3'b010 : 3'b001) : 3'b100);
    chk(req, int'(rdata_o), (exp_ok && !wr) ? int'(RD_PAT) : 0);
    @(negedge clk);
    acc_valid_i = 0; acc_write_i = 0; acc_priv_i = 0;
  endtask

  task automatic start_conv();
    @(negedge clk); conv_start_i = 1;
    @(negedge clk); conv_start_i = 0;
  endtask

  task automatic t_reset();
    #2;
    chk("R1 reset qclk", qclk_en_o, 1);
    chk("R1 reset timer", timer_rst_o, 0);
    chk("R7 reset ready", conv_ready_o, 1);
    chk("R6 reset clr", clr_vec_o, 0);
  endtask

  task automatic t_stop();
    start_conv();
    chk("R2 busy before stop", seq_busy_o, 1);
    stop_i = 1; #2;
    chk("R2 abort pulse", seq_abort_o, 1);
    chk("R6 clr pulse", clr_vec_o, 8'h60);
    chk("R1 qclk off", qclk_en_o, 0);
    chk("R1 timer reset", timer_rst_o, 1);
    chk("R1 start blocked", start_ok_o, 0);
    @(negedge clk);
    chk("R2 abort one cycle", seq_abort_o, 0);
    chk("R2 busy cleared", seq_busy_o, 0);
    chk("R6 clr one cycle", clr_vec_o, 0);
    for (int g = 0; g < 3; g++) begin
      access("R3 stop rw read", g, 0, 1, 1);
      access("R3 stop rw write", g, 1, 1, 1);
    end
    for (int g = 3; g < 7; g++) begin
      access("R4 stop ro read", g, 0, 1, 1);
      access("R4 stop ro write", g, 1, 1, 0);
    end
    access("R5 ram read", 7, 0, 1, 0);
    access("R5 ram write", 7, 1, 1, 0);
  endtask

  task automatic t_recovery();
    @(negedge clk); stop_i = 0;
    for (int k = 1; k <= int'(REC); k++) begin
      @(negedge clk);
      if (k == int'(REC) - 1) chk("R7 not ready before expiry", conv_ready_o, 0);
      if (k == int'(REC))     chk("R7 ready at expiry", conv_ready_o, 1);
    end
    chk("R7 start ok after recovery", start_ok_o, 1);
  endtask

  task automatic t_freeze();
    frz_en_i = 1;
    start_conv();
    freeze_i = 1;
    repeat (3) @(negedge clk);
    chk("R8 busy held under freeze", seq_busy_o, 1);
    chk("R8 no halt while busy", seq_halt_o, 0);
    chk("R8 no abort", seq_abort_o, 0);
    conv_done_i = 1;
    @(negedge clk); conv_done_i = 0;
    chk("R8 done clears busy", seq_busy_o, 0);
    chk("R8 halt", seq_halt_o, 1);
    chk("R8 start blocked", start_ok_o, 0);
    start_conv();
    chk("R8 start ignored when halted", seq_busy_o, 0);
    @(negedge clk); freeze_i = 0; #2;
    chk("R8 release", start_ok_o, 1);
    frz_en_i = 0;
  endtask

  task automatic t_freeze_off();
    @(negedge clk); frz_en_i = 0; freeze_i = 1; #2;
    chk("R9 halt off", seq_halt_o, 0);
    chk("R9 start ok", start_ok_o, 1);
    start_conv();
    chk("R9 start taken", seq_busy_o, 1);
    @(negedge clk); conv_done_i = 1;
    @(negedge clk); conv_done_i = 0; freeze_i = 0;
  endtask

  task automatic t_priv();
    supv_i = 0;
    for (int g = 0; g < 3; g++) access("R10 user to base priv", g, 0, 0, 0);
    for (int g = 3; g < 8; g++) access("R10 user to open", g, 1, 0, 1);
    access("R12 accepted read", 7, 0, 0, 1);
    supv_i = 1;
    for (int g = 0; g < 8; g++) access("R11 user refused", g, 0, 0, 0);
    access("R11 supervisor write", 7, 1, 1, 1);
    access("R11 supervisor read", 0, 0, 1, 1);
    supv_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_stop();
    t_recovery();
    t_freeze();
    t_freeze_off();
    t_priv();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule